// File: doc/BRIEF.md
# Accumulator Machine Core

This block is a minimal processor built around one 32-bit accumulator. It executes one instruction at a time from a unified, byte-addressed memory of 2^24 bytes. Every instruction occupies four bytes: an operation byte followed by a 24-bit operand address. The accumulator is always one of the sources and is the only destination. The only exception is the store, which copies the accumulator into memory.

The core fetches the four instruction bytes one by one through a single synchronous byte port. The port has one cycle of read latency. The core then decodes the operation byte and reads or writes the 32-bit operand as four big-endian bytes. For the arithmetic operations it updates the accumulator and then moves the program counter on by four. An operation byte it does not recognise stops the machine. A halt output and a copy of the accumulator let the surrounding logic see when the program is done and what it computed.

Top module: `accum_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter and the accumulator to zero and deasserts `halted`. While reset is held, `memAddr` shows 0 and `memWe` is low.
- R2: An instruction is fetched from PC, PC+1, PC+2 and PC+3. The byte at PC is the operation code. The next three bytes give the operand address, most significant byte first (bits 23:16 at PC+1).
- R3: Operation 0x01 (load) sets the accumulator to the 32-bit word at the operand address. The byte at that address is the most significant byte. The address may be unaligned.
- R4: Operation 0x02 (store) writes the accumulator to the four bytes starting at the operand address, most significant byte first. It makes exactly four byte writes and changes no other byte.
- R5: Operation 0x03 (add) sets the accumulator to the accumulator plus the memory word, modulo 2^32.
- R6: Operation 0x04 (sub) sets the accumulator to the accumulator minus the memory word, modulo 2^32.
- R7: Operation 0x05 (mul) sets the accumulator to the low 32 bits of the accumulator times the memory word.
- R8: After each load, store, add, sub or mul, the program counter advances by 4. Instructions therefore execute in address order.
- R9: Operation 0xFF stops the core. `halted` rises and stays high until reset, with no further memory writes and no change to the accumulator.
- R10: Every operation code other than 0x01 to 0x05 stops the core in the same way as 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 24 | Byte address presented to memory |
| memRdata | input | 8 | Read byte, valid one cycle after its address |
| memWdata | output | 8 | Byte to write |
| memWe | output | 1 | Write enable for the byte at memAddr |
| halted | output | 1 | High once the core has stopped |
| accDbg | output | 32 | Current accumulator value |

## Verification
Each arithmetic operation runs over every ordered pair from a set of eight words chosen to hit carries, borrows and overflow: zero, one, all ones, the sign bit alone, the largest positive value, and mixed patterns. Each result is checked both in the accumulator and in the stored memory word, so a wrong byte order or a wrong wrap shows up in one place or the other. The five-instruction expression (B + C) * D - E is run with the same values to exercise chaining and sequential program counter steps. Operand addresses carry distinct upper bytes, so a swapped address byte would point at different data. The sweep over all 256 operation codes places each unknown code between a load and a store. It then confirms that the accumulator keeps the loaded value, that no write occurs, and that the core stays halted.

// File: rtl/accum_pkg.sv
package accum_pkg;

  localparam int ADDR_W      = 24;
  localparam int WORD_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int OPC_W       = 8;
  localparam int WORD_BYTES  = WORD_W / BYTE_W;
  localparam int INSTR_W     = OPC_W + ADDR_W;
  localparam int INSTR_BYTES = INSTR_W / BYTE_W;
  localparam int MAX_BYTES   = (WORD_BYTES > INSTR_BYTES) ? WORD_BYTES : INSTR_BYTES;
  localparam int SEL_W       = $clog2(MAX_BYTES);
  localparam int CNT_W       = SEL_W + 1;

  localparam logic [OPC_W-1:0] OP_LOAD  = 8'h01;
  localparam logic [OPC_W-1:0] OP_STORE = 8'h02;
  localparam logic [OPC_W-1:0] OP_ADD   = 8'h03;
  localparam logic [OPC_W-1:0] OP_SUB   = 8'h04;
  localparam logic [OPC_W-1:0] OP_MUL   = 8'h05;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_READ, ST_EXEC, ST_WRITE, ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_MUL
  } alu_e;

  typedef struct packed {
    logic             useOperAddr;
    logic [SEL_W-1:0] byteSel;
    logic             capInstr;
    logic             capOper;
    logic             wrEn;
    logic             accLoad;
    alu_e             aluOp;
    logic             pcStep;
  } ctrl_s;

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctrl_s            ctl,
  output logic             halted
);

  state_e           state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      cnt   <= '0;
    end else begin
      case (state)
        ST_FETCH: begin
          if (cnt == CNT_W'(INSTR_BYTES)) begin
            state <= ST_DECODE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DECODE: begin
          cnt <= '0;
          case (opcode)
            OP_LOAD, OP_ADD, OP_SUB, OP_MUL: state <= ST_READ;
            OP_STORE:                        state <= ST_WRITE;
            default:                         state <= ST_HALT;
          endcase
        end
        ST_READ: begin
          if (cnt == CNT_W'(WORD_BYTES)) begin
            state <= ST_EXEC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_EXEC: state <= ST_FETCH;
        ST_WRITE: begin
          if (cnt == CNT_W'(WORD_BYTES - 1)) begin
            state <= ST_FETCH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    ctl.aluOp = ALU_PASS;
    case (state)
      ST_FETCH: begin
        ctl.byteSel  = cnt[SEL_W-1:0];
        ctl.capInstr = (cnt != '0);
      end
      ST_READ: begin
        ctl.useOperAddr = 1'b1;
        ctl.byteSel     = cnt[SEL_W-1:0];
        ctl.capOper     = (cnt != '0);
      end
      ST_EXEC: begin
        ctl.accLoad = 1'b1;
        ctl.pcStep  = 1'b1;
        case (opcode)
          OP_ADD:  ctl.aluOp = ALU_ADD;
          OP_SUB:  ctl.aluOp = ALU_SUB;
          OP_MUL:  ctl.aluOp = ALU_MUL;
          default: ctl.aluOp = ALU_PASS;
        endcase
      end
      ST_WRITE: begin
        ctl.useOperAddr = 1'b1;
        ctl.byteSel     = cnt[SEL_W-1:0];
        ctl.wrEn        = 1'b1;
        ctl.pcStep      = (cnt == CNT_W'(WORD_BYTES - 1));
      end
      default: ;
    endcase
  end

  assign halted = (state == ST_HALT);

  // R9: once stopped, the core stays stopped until reset
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9: no memory write while stopped
  a_r9_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ctl.wrEn);

  // R2: at most one capture or write action per cycle
  a_r2_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.capInstr, ctl.capOper, ctl.wrEn, ctl.accLoad}));

  // R4: a store is a contiguous burst, never a lone byte
  a_r4_write_burst: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.wrEn) |=> ctl.wrEn);

endmodule

// File: rtl/accum_dp.sv
module accum_dp
  import accum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_s             ctl,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  output logic [OPC_W-1:0]  opcode,
  output logic [WORD_W-1:0] acc
);

  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] instr;
  logic [WORD_W-1:0]  oper;
  logic [WORD_W-1:0]  aluRes;
  logic [ADDR_W-1:0]  operAddr;
  logic [ADDR_W-1:0]  baseAddr;

  assign operAddr = instr[ADDR_W-1:0];
  assign opcode   = instr[INSTR_W-1 -: OPC_W];
  assign baseAddr = ctl.useOperAddr ? operAddr : pc;
  assign memAddr  = baseAddr + ADDR_W'(ctl.byteSel);
  assign memWdata = acc[BYTE_W*(WORD_BYTES-1-int'(ctl.byteSel)) +: BYTE_W];
  assign memWe    = ctl.wrEn;

  always_comb begin
    case (ctl.aluOp)
      ALU_ADD: aluRes = acc + oper;
      ALU_SUB: aluRes = acc - oper;
      ALU_MUL: aluRes = acc * oper;
      default: aluRes = oper;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      acc   <= '0;
      instr <= '0;
      oper  <= '0;
    end else begin
      if (ctl.capInstr) instr <= {instr[INSTR_W-BYTE_W-1:0], memRdata};
      if (ctl.capOper)  oper  <= {oper[WORD_W-BYTE_W-1:0], memRdata};
      if (ctl.accLoad)  acc   <= aluRes;
      if (ctl.pcStep)   pc    <= pc + ADDR_W'(INSTR_BYTES);
    end
  end

  // R8: the program counter either holds or steps by one instruction
  a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc == $past(pc)) || (pc == $past(pc) + ADDR_W'(INSTR_BYTES)));

  // R3: the accumulator changes only in an execute cycle
  a_r3_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.accLoad |=> $stable(acc));

  // R2: the instruction register is frozen outside fetch
  a_r2_instr_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.capInstr |=> $stable(instr));

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  output logic              halted,
  output logic [WORD_W-1:0] accDbg
);

  ctrl_s            ctl;
  logic [OPC_W-1:0] opcode;

  accum_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctl    (ctl),
    .halted (halted)
  );

  accum_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .opcode   (opcode),
    .acc      (accDbg)
  );

endmodule

// File: tb/accum_core_bench.sv
`timescale 1ns/1ps
module accum_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] memAddr;
  logic [7:0]  memRdata;
  logic [7:0]  memWdata;
  logic        memWe;
  logic        halted;
  logic [31:0] accDbg;

  logic        tbWe = 1'b0;
  logic [11:0] tbAddr = '0;
  logic [7:0]  tbData = '0;
  logic [7:0]  mem [0:4095];
  int          wrCount = 0;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] vals [8];

  always #2 clk = ~clk;

  accum_core u_accum_core (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRdata(memRdata),
    .memWdata(memWdata), .memWe(memWe), .halted(halted), .accDbg(accDbg)
  );

  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memWe) mem[memAddr[11:0]] <= memWdata;
    memRdata <= mem[memAddr[11:0]];
    if (memWe) wrCount <= wrCount + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic putWord(input logic [11:0] a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) poke(a + 12'(k), w[31-8*k -: 8]);
  endtask

  task automatic putInstr(input logic [11:0] a, input logic [7:0] op, input logic [23:0] ea);
    poke(a, op);
    poke(a + 12'd1, ea[23:16]);
    poke(a + 12'd2, ea[15:8]);
    poke(a + 12'd3, ea[7:0]);
  endtask

  function automatic logic [31:0] peekWord(input logic [11:0] a);
    return {mem[a], mem[a+12'd1], mem[a+12'd2], mem[a+12'd3]};
  endfunction

  task automatic beginLoad();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic runProg();
    // R1: reset state visible while reset is held
    chk("R1 reset acc", accDbg, 32'h0);
    chk("R1 reset halted/addr/we", {7'd0, halted, memAddr}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3000 && !halted; k++) @(negedge clk);
    if (!halted) chk("R8 program reached halt", 32'd0, 32'd1);
  endtask

  // addresses: operand X, Y, store target Z (bench index = low 12 bits)
  localparam logic [23:0] EA_X = 24'h7E0200;
  localparam logic [23:0] EA_Y = 24'h120305;
  localparam logic [23:0] EA_Z = 24'h5A0411;

  initial begin
    vals[0] = 32'h00000000; vals[1] = 32'h00000001;
    vals[2] = 32'hFFFFFFFF; vals[3] = 32'h80000000;
    vals[4] = 32'h7FFFFFFF; vals[5] = 32'h12345678;
    vals[6] = 32'hDEADBEEF; vals[7] = 32'h00010000;

    // R3: load of an unaligned big-endian word
    beginLoad();
    putInstr(12'h000, 8'h01, EA_Y);
    putInstr(12'h004, 8'hFF, 24'h0);
    putWord(12'h305, 32'h11223344);
    runProg();
    chk("R3 load big-endian unaligned", accDbg, 32'h11223344);

    // R5 R6 R7 R4 R8: every ordered pair for each arithmetic op
    for (int o = 3; o <= 5; o++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [31:0] expv;
          int wr0;
          string tag;
          case (o)
            3: begin expv = vals[i] + vals[j]; tag = "R5 add wrap"; end
            4: begin expv = vals[i] - vals[j]; tag = "R6 sub wrap"; end
            default: begin expv = vals[i] * vals[j]; tag = "R7 mul low"; end
          endcase
          beginLoad();
          putInstr(12'h000, 8'h01, EA_X);
          putInstr(12'h004, 8'(o), EA_Y);
          putInstr(12'h008, 8'h02, EA_Z);
          putInstr(12'h00C, 8'hFF, 24'h0);
          putWord(12'h200, vals[i]);
          putWord(12'h305, vals[j]);
          poke(12'h410, 8'hA5);
          poke(12'h415, 8'hA5);
          wr0 = wrCount;
          runProg();
          chk(tag, accDbg, expv);
          chk("R4 stored word", peekWord(12'h411), expv);
          chk("R4 neighbours and write count",
              {mem[12'h410], mem[12'h415], 16'(wrCount - wr0)}, {16'hA5A5, 16'd4});
        end
      end
    end

    // R8 R2: five-instruction expression (B + C) * D - E, stored to A
    for (int i = 0; i < 8; i++) begin
      logic [31:0] b, c, d, e, expv;
      b = vals[i]; c = vals[(i+3)%8]; d = vals[(i+5)%8]; e = vals[(i+1)%8];
      expv = (b + c) * d - e;
      beginLoad();
      putInstr(12'h000, 8'h01, 24'h7E0200);
      putInstr(12'h004, 8'h03, 24'h010208);
      putInstr(12'h008, 8'h05, 24'hFF0210);
      putInstr(12'h00C, 8'h04, 24'h330218);
      putInstr(12'h010, 8'h02, EA_Z);
      putInstr(12'h014, 8'hFF, 24'h0);
      putWord(12'h200, b);
      putWord(12'h208, c);
      putWord(12'h210, d);
      putWord(12'h218, e);
      runProg();
      chk("R8 expression acc", accDbg, expv);
      chk("R8 expression stored", peekWord(12'h411), expv);
    end

    // R9 R10: every operation code outside 0x01..0x05 stops the core
    for (int op = 0; op < 256; op++) begin
      if (op >= 1 && op <= 5) continue;
      begin
        int wr0;
        beginLoad();
        putInstr(12'h000, 8'h01, EA_X);
        putInstr(12'h004, 8'(op), EA_Z);
        putInstr(12'h008, 8'h02, EA_Z);
        putInstr(12'h00C, 8'hFF, 24'h0);
        putWord(12'h200, 32'hC0FFEE11);
        putWord(12'h411, 32'h00000000);
        wr0 = wrCount;
        runProg();
        repeat (20) @(negedge clk);
        if (op == 255)
          chk("R9 halt sticky, acc kept, no write",
              {halted, peekWord(12'h411) == 32'h0, wrCount == wr0, accDbg[28:0]},
              {3'b111, 29'h00FFEE11});
        else
          chk("R10 unknown opcode halts",
              {halted, peekWord(12'h411) == 32'h0, wrCount == wr0, accDbg[28:0]},
              {3'b111, 29'h00FFEE11});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule